// File: doc/BRIEF.md
# Cascadable Match Priority Encoder

This block turns the per-entry hit vector of an associative lookup array into a single result index. The lowest hit index wins, so a table kept with longer prefixes at lower indices returns its longest match. Alongside the index it presents a 4-bit page number taken from configuration. The result and page are meant to drive a bus that several devices share, so the block also produces a bus-enable signal that stands in for the output tri-state.

Devices form a daisy chain. Each device passes an active-low hit flag to the next device down, which takes it as its chain input. A device whose chain input shows a hit above it keeps off the shared bus. The topmost device that hits drives the bus whatever its output-enable says. When no device in the chain hits, only the device configured as the last one drives an all-ones miss code. A second chain of the same shape, carrying occupancy, reports when the whole system is full.

The presented result goes through a hold latch. While the hold-open input is low the bus value is frozen, and it takes up the newest result on the first cycle the input is high. Besides compare results, the block can present a plain memory-access address. That does not disturb the hit flag, which always reports the latest compare.

Top module: `cascade_prio_enc`

## Requirements
- R1: After a compare, the presented result is the lowest index whose bit in the hit vector is 1.
- R2: One cycle after a compare strobe, matchFlagN is 0 if the hit vector had any 1 or matchInN was 0 at the strobe. Otherwise it is 1.
- R3: matchFlagN changes only in the cycle after a compare strobe. Access cycles and idle cycles leave it unchanged.
- R4: After a compare with a local hit and matchInN = 1, busEnable is 1 whatever the value of oeN.
- R5: After a compare with matchInN = 0, busEnable is 0 whatever the value of oeN.
- R6: After a compare with no local hit and matchInN = 1, busEnable equals lastDevice. When lastDevice is 1, resultAddr is all ones.
- R7: After an access strobe with no compare strobe in the same cycle, resultAddr equals the captured accessAddr and busEnable equals the inverse of oeN.
- R8: pageOut equals pageCfg while busEnable is 1, and is 0 otherwise.
- R9: While latchOpen is 0, resultAddr holds its value. A result captured during the hold appears one cycle after latchOpen returns to 1.
- R10: One cycle after any edge, fullFlagN is 0 exactly when every validVec bit was 1 and fullInN was 0.
- R11: During and right after reset, matchFlagN = 1, fullFlagN = 1, busEnable = 0 and resultAddr = 0.
- R12: When cmpStrobe and accStrobe are both 1 in the same cycle, the compare wins and accessAddr is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| matchVec | input | DEPTH | Per-entry hit bits from the array |
| validVec | input | DEPTH | Per-entry occupied bits |
| cmpStrobe | input | 1 | Capture a compare result this cycle |
| accStrobe | input | 1 | Capture an access address this cycle |
| accessAddr | input | IDX_W | Address of a non-compare memory access |
| latchOpen | input | 1 | 1: presented result may update; 0: hold |
| oeN | input | 1 | Output enable for access results, active low |
| matchInN | input | 1 | Hit flag from the device above, active low |
| fullInN | input | 1 | Full flag from the device above, active low |
| lastDevice | input | 1 | This device is the lowest in the chain |
| pageCfg | input | PAGE_W | Configured page number |
| resultAddr | output | IDX_W | Presented index or miss code |
| pageOut | output | PAGE_W | Page number presented with the result |
| busEnable | output | 1 | This device drives the shared result bus |
| matchFlagN | output | 1 | Chain hit flag, active low |
| fullFlagN | output | 1 | Chain full flag, active low |

## Verification
The bench builds the block with DEPTH = 16, so IDX_W = 4 and PAGE_W = 4. A full valid vector is then easy to reach and easy to leave again. Every hit position, including the top index whose value equals the miss code, shows up under random sparse hit vectors. Directed cases cover the chain positions one by one: top with a hit, below a hit, and last or not-last on a miss. They also cover the hold latch and the case where a compare and an access arrive in the same cycle.

// File: rtl/cascade_prio_pkg.sv
package cascade_prio_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CMP  = 2'd1,
    MODE_ACC  = 2'd2
  } pe_mode_t;

  typedef struct packed {
    logic loadCmp;
    logic loadAcc;
    logic showNew;
  } pe_strobe_t;

endpackage

// File: rtl/cascade_prio_datapath.sv
module cascade_prio_datapath
  import cascade_prio_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DEPTH-1:0] matchVec,
  input  logic [IDX_W-1:0] accessAddr,
  input  pe_strobe_t       strobes,
  output logic             anyHit,
  output logic [IDX_W-1:0] resultAddr
);

  localparam logic [IDX_W-1:0] MISS_CODE = '1;

  logic [IDX_W-1:0] winIdx;
  logic [IDX_W-1:0] pendAddr;

  // lowest set index wins: scan downward so the last assignment is the lowest
  always_comb begin
    winIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (matchVec[i]) winIdx = IDX_W'(i);
    end
  end

  assign anyHit = |matchVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr <= '0;
    end else if (strobes.loadCmp) begin
      pendAddr <= anyHit ? winIdx : MISS_CODE;
    end else if (strobes.loadAcc) begin
      pendAddr <= accessAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultAddr <= '0;
    end else if (strobes.showNew) begin
      resultAddr <= pendAddr;
    end
  end

endmodule

// File: rtl/cascade_prio_ctrl.sv
module cascade_prio_ctrl
  import cascade_prio_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpStrobe,
  input  logic             accStrobe,
  input  logic             latchOpen,
  input  logic             anyHit,
  input  logic             matchInN,
  input  logic             oeN,
  input  logic             lastDevice,
  input  logic [DEPTH-1:0] validVec,
  input  logic             fullInN,
  output pe_strobe_t       strobes,
  output logic             busEnable,
  output logic             matchFlagN,
  output logic             fullFlagN
);

  pe_mode_t pendMode, shownMode;
  logic     pendHit, shownHit;
  logic     pendAbove, shownAbove;

  always_comb begin
    strobes.loadCmp = cmpStrobe;
    strobes.loadAcc = accStrobe && !cmpStrobe;
    strobes.showNew = latchOpen;
  end

  // capture stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMode   <= MODE_IDLE;
      pendHit    <= 1'b0;
      pendAbove  <= 1'b0;
      matchFlagN <= 1'b1;
    end else if (strobes.loadCmp) begin
      pendMode   <= MODE_CMP;
      pendHit    <= anyHit;
      pendAbove  <= !matchInN;
      matchFlagN <= !(anyHit || !matchInN);
    end else if (strobes.loadAcc) begin
      pendMode   <= MODE_ACC;
    end
  end

  // presentation latch stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shownMode  <= MODE_IDLE;
      shownHit   <= 1'b0;
      shownAbove <= 1'b0;
    end else if (strobes.showNew) begin
      shownMode  <= pendMode;
      shownHit   <= pendHit;
      shownAbove <= pendAbove;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fullFlagN <= 1'b1;
    else       fullFlagN <= !((&validVec) && !fullInN);
  end

  always_comb begin
    unique case (shownMode)
      MODE_CMP: busEnable = shownAbove ? 1'b0 : (shownHit ? 1'b1 : lastDevice);
      MODE_ACC: busEnable = !oeN;
      default:  busEnable = 1'b0;
    endcase
  end

endmodule

// File: rtl/cascade_prio_enc.sv
module cascade_prio_enc
  import cascade_prio_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int PAGE_W = 4,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DEPTH-1:0]  matchVec,
  input  logic [DEPTH-1:0]  validVec,
  input  logic              cmpStrobe,
  input  logic              accStrobe,
  input  logic [IDX_W-1:0]  accessAddr,
  input  logic              latchOpen,
  input  logic              oeN,
  input  logic              matchInN,
  input  logic              fullInN,
  input  logic              lastDevice,
  input  logic [PAGE_W-1:0] pageCfg,
  output logic [IDX_W-1:0]  resultAddr,
  output logic [PAGE_W-1:0] pageOut,
  output logic              busEnable,
  output logic              matchFlagN,
  output logic              fullFlagN
);

  pe_strobe_t strobes;
  logic       anyHit;

  cascade_prio_ctrl #(.DEPTH(DEPTH)) ctrlInst (
    .clk(clk), .rstN(rstN), .cmpStrobe(cmpStrobe), .accStrobe(accStrobe),
    .latchOpen(latchOpen), .anyHit(anyHit), .matchInN(matchInN), .oeN(oeN),
    .lastDevice(lastDevice), .validVec(validVec), .fullInN(fullInN),
    .strobes(strobes), .busEnable(busEnable), .matchFlagN(matchFlagN),
    .fullFlagN(fullFlagN)
  );

  cascade_prio_datapath #(.DEPTH(DEPTH), .IDX_W(IDX_W)) dpInst (
    .clk(clk), .rstN(rstN), .matchVec(matchVec), .accessAddr(accessAddr),
    .strobes(strobes), .anyHit(anyHit), .resultAddr(resultAddr)
  );

  assign pageOut = busEnable ? pageCfg : '0;

endmodule

// File: rtl/cascade_prio_checker.sv
module cascade_prio_checker #(
  parameter int DEPTH  = 64,
  parameter int PAGE_W = 4,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rstN,
  input logic [DEPTH-1:0]  matchVec,
  input logic [DEPTH-1:0]  validVec,
  input logic              cmpStrobe,
  input logic              latchOpen,
  input logic              matchInN,
  input logic              fullInN,
  input logic [PAGE_W-1:0] pageCfg,
  input logic [IDX_W-1:0]  resultAddr,
  input logic [PAGE_W-1:0] pageOut,
  input logic              busEnable,
  input logic              matchFlagN,
  input logic              fullFlagN
);

  a_r2_flag_after_compare: assert property (@(posedge clk) disable iff (!rstN)
    cmpStrobe |=> (matchFlagN == !((|$past(matchVec)) || !$past(matchInN))));

  a_r3_flag_steady: assert property (@(posedge clk) disable iff (!rstN)
    !cmpStrobe |=> $stable(matchFlagN));

  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rstN)
    !latchOpen |=> $stable(resultAddr));

  a_r8_page_driven: assert property (@(posedge clk) disable iff (!rstN)
    busEnable |-> (pageOut == pageCfg));

  a_r8_page_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busEnable |-> (pageOut == '0));

  a_r10_full_chain: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (fullFlagN == !((&$past(validVec)) && !$past(fullInN))));

endmodule

bind cascade_prio_enc cascade_prio_checker #(
  .DEPTH(DEPTH), .PAGE_W(PAGE_W), .IDX_W(IDX_W)
) checkInst (
  .clk(clk), .rstN(rstN), .matchVec(matchVec), .validVec(validVec),
  .cmpStrobe(cmpStrobe), .latchOpen(latchOpen), .matchInN(matchInN),
  .fullInN(fullInN), .pageCfg(pageCfg), .resultAddr(resultAddr),
  .pageOut(pageOut), .busEnable(busEnable), .matchFlagN(matchFlagN),
  .fullFlagN(fullFlagN)
);

// File: tb/cascade_prio_enc_test.sv
module cascade_prio_enc_test;
  localparam int DEPTH  = 16;
  localparam int PAGE_W = 4;
  localparam int IDX_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DEPTH-1:0] matchVec = '0, validVec = '0;
  logic cmpStrobe = 0, accStrobe = 0, latchOpen = 1, oeN = 1;
  logic matchInN = 1, fullInN = 1, lastDevice = 0;
  logic [IDX_W-1:0] accessAddr = '0;
  logic [PAGE_W-1:0] pageCfg = 4'hA;
  logic [IDX_W-1:0] resultAddr;
  logic [PAGE_W-1:0] pageOut;
  logic busEnable, matchFlagN, fullFlagN;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cascade_prio_enc #(.DEPTH(DEPTH), .PAGE_W(PAGE_W)) uut (
    .clk(clk), .rstN(rstN), .matchVec(matchVec), .validVec(validVec),
    .cmpStrobe(cmpStrobe), .accStrobe(accStrobe), .accessAddr(accessAddr),
    .latchOpen(latchOpen), .oeN(oeN), .matchInN(matchInN), .fullInN(fullInN),
    .lastDevice(lastDevice), .pageCfg(pageCfg), .resultAddr(resultAddr),
    .pageOut(pageOut), .busEnable(busEnable), .matchFlagN(matchFlagN),
    .fullFlagN(fullFlagN)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowIdx(input logic [DEPTH-1:0] mv);
    for (int i = 0; i < DEPTH; i++) if (mv[i]) return i;
    return (1 << IDX_W) - 1;
  endfunction

  // compare, then one more edge for the presentation latch; sample at negedge
  task automatic doCompare(input logic [DEPTH-1:0] mv, input logic mi,
                           input logic oe, input logic last);
    logic expFlag, expEn;
    @(negedge clk);
    matchVec = mv; matchInN = mi; cmpStrobe = 1;
    @(posedge clk); @(negedge clk);
    cmpStrobe = 0; oeN = oe; lastDevice = last;
    expFlag = !((mv != 0) || !mi);
    chk("R2 match flag", matchFlagN, expFlag);
    @(posedge clk); @(negedge clk);
    expEn = !mi ? 1'b0 : ((mv != 0) ? 1'b1 : last);
    if (!mi)           chk("R5 below a hit", busEnable, expEn);
    else if (mv != 0)  chk("R4 local hit", busEnable, expEn);
    else               chk("R6 miss drive", busEnable, expEn);
    if (expEn) chk("R1/R6 result index", resultAddr, lowIdx(mv));
    chk("R8 page", pageOut, expEn ? pageCfg : 0);
  endtask

  initial begin
    int seed;
    logic savedFlag;
    logic [IDX_W-1:0] held;
    seed = $urandom(32'd2024);
    #12 @(negedge clk);
    chk("R11 reset flag", matchFlagN, 1);
    chk("R11 reset full", fullFlagN, 1);
    chk("R11 reset enable", busEnable, 0);
    chk("R11 reset addr", resultAddr, 0);
    rstN = 1;
    @(negedge clk);
    chk("R11 after reset enable", busEnable, 0);

    // directed chain positions
    doCompare(16'h0000, 1, 0, 1);          // R6 last device miss -> all ones
    doCompare(16'h0000, 1, 0, 0);          // R6 not last -> quiet
    doCompare(16'h8000, 1, 1, 0);          // R4 top index, oe inactive
    doCompare(16'h0011, 0, 0, 1);          // R5 hit above, oe active
    doCompare(16'h0001, 1, 1, 1);          // R1 index 0
    doCompare(16'hF0F0, 1, 0, 0);          // R1 lowest of many

    // R7 access and R3 flag unaffected
    savedFlag = matchFlagN;
    @(negedge clk); accessAddr = 4'd9; accStrobe = 1; oeN = 0;
    @(posedge clk); @(negedge clk); accStrobe = 0;
    @(posedge clk); @(negedge clk);
    chk("R7 access addr", resultAddr, 9);
    chk("R7 access enable", busEnable, 1);
    chk("R3 flag after access", matchFlagN, savedFlag);
    oeN = 1; #1;
    chk("R7 access oe off", busEnable, 0);

    // R12 simultaneous strobes
    @(negedge clk); matchVec = 16'h0040; matchInN = 1; cmpStrobe = 1;
    accStrobe = 1; accessAddr = 4'd2;
    @(posedge clk); @(negedge clk); cmpStrobe = 0; accStrobe = 0;
    @(posedge clk); @(negedge clk);
    chk("R12 compare wins", resultAddr, 6);

    // R9 hold latch
    held = resultAddr;
    @(negedge clk); latchOpen = 0; matchVec = 16'h0008; cmpStrobe = 1;
    @(posedge clk); @(negedge clk); cmpStrobe = 0;
    @(posedge clk); @(negedge clk);
    chk("R9 held", resultAddr, held);
    latchOpen = 1;
    @(posedge clk); @(negedge clk);
    chk("R9 released", resultAddr, 3);

    // R10 full chain
    @(negedge clk); validVec = '1; fullInN = 0;
    @(posedge clk); @(negedge clk);
    chk("R10 full", fullFlagN, 0);
    validVec = 16'hFFFE;
    @(posedge clk); @(negedge clk);
    chk("R10 one empty", fullFlagN, 1);
    validVec = '1; fullInN = 1;
    @(posedge clk); @(negedge clk);
    chk("R10 above not full", fullFlagN, 1);

    // random
    for (int n = 0; n < 60; n++) begin
      logic [DEPTH-1:0] mv;
      mv = DEPTH'($urandom & $urandom & $urandom);
      if ($urandom % 5 == 0) mv = '0;
      doCompare(mv, ($urandom % 4) != 0, $urandom % 2, $urandom % 2);
      @(negedge clk);
      validVec = ($urandom % 3 == 0) ? '1 : DEPTH'($urandom);
      fullInN = $urandom % 2;
      @(posedge clk); @(negedge clk);
      chk("R10 random full", fullFlagN, !((&validVec) && !fullInN));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule